// File: doc/BRIEF.md
# Divider Code Change Filter

This block sits between a converter that keeps re-reading a divider-setting code and the logic that uses that code. The raw code may wander or pass through transitional values while the setting is being changed. The block publishes an effective code only after a candidate value has stayed unchanged for a settle interval. That interval is counted in master-oscillator ticks and grows with the candidate's own value. The effective code therefore moves straight from the old setting to the new one and never shows anything in between.

The block runs on the system clock, with a one-cycle tick enable marking each master-oscillator period. The raw code is looked at only on ticked edges. When reset ends, the first sampled raw value is taken as the effective code at once, with no filtering. After that the block keeps watching for changes for as long as it runs. When the effective code changes, a one-cycle strobe marks the update. A delay interval that is already running downstream may end with a length between the old and new settings. That is allowed and is not handled here.

Top module: `divcode_settle_filter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `eff_code` reads 0 and `upd_strobe` reads 0 after that edge.
- R2: At the first clock edge with `rst_n` high after reset, `eff_code` takes the value of `raw_code` directly, whatever the state of `tick`, and `upd_strobe` stays 0.
- R3: A candidate code N different from `eff_code` is published only after `raw_code` has equalled N on L+1 consecutive ticked edges, where L = 16 × (N + 6) and N is read as an unsigned 4-bit value from 0 to 15. `eff_code` becomes N right after the (L+1)-th such edge and is unchanged after the L-th.
- R4: If `raw_code` moves to a different value while a candidate is qualifying, the count restarts from zero for the new value, and the abandoned candidate is never published.
- R5: If `raw_code` returns to the current `eff_code` while a candidate is qualifying, the qualification is cancelled and no update occurs. A later attempt with the same candidate needs the full L+1 ticked edges again.
- R6: Clock edges with `tick` low neither advance nor restart a qualification, and `raw_code` values present only on such edges have no effect.
- R7: `upd_strobe` is 1 for exactly the one cycle following the edge at which `eff_code` changes. Outside the load that ends reset, `eff_code` never changes without it.
- R8: `eff_code` never takes an intermediate value: whenever `upd_strobe` is 1, `eff_code` equals the `raw_code` sampled at the preceding edge.
- R9: While `raw_code` equals `eff_code`, the block produces no strobe and no change, however long this lasts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle enable, one per master-oscillator period |
| raw_code | input | 4 | Raw divider code from the converter |
| eff_code | output | 4 | Filtered effective divider code |
| upd_strobe | output | 1 | One-cycle pulse after the effective code changes |

## Verification
The embedded properties check the following on every cycle:
- the strobe appears only after a ticked edge and lasts a single cycle;
- every change of the effective code comes with the strobe, and the published value equals the raw code of the previous edge;
- the settle counter stays below the limit of the current candidate;
- the candidate holds still on untimed edges;
- the idle state always has the candidate equal to the effective code;
- the code loaded after reset is the raw value.

The exact settle length for each code value cannot be shown by these properties and is left to the bench scenarios. So are the restart after a candidate switch, the full recount after a cancelled attempt, and the way progress is kept across gaps in the tick.

// File: rtl/dcf_pkg.sv
// Package: shared types and sizing helpers for the divider code filter.
// Assumes: callers pass positive widths and a settle scale of at least 1.
package dcf_pkg;

    // Phases of the publishing controller.
    typedef enum logic [1:0] {
        DCF_BOOT = 2'd0,   // waiting for the first sample after reset
        DCF_IDLE = 2'd1,   // candidate equals effective code
        DCF_QUAL = 2'd2    // a differing candidate is being timed
    } dcf_phase_e;

    // Width needed to hold the largest settle limit for a given code width.
    function automatic int unsigned dcf_count_width(
        input int unsigned code_w,
        input int unsigned scale,
        input int unsigned offset
    );
        int unsigned max_limit;
        max_limit = scale * (((1 << code_w) - 1) + offset);
        return $clog2(max_limit + 1);
    endfunction

endpackage

// File: rtl/dcf_limit_calc.sv
// Module: dcf_limit_calc
// Computes the settle limit SCALE * (code + OFFSET) for the current candidate.
// Assumes: CNT_W is wide enough for the largest code (sized by the top).
// A power-of-two SCALE turns into a shift; any other value uses a multiplier.
module dcf_limit_calc #(
    parameter int unsigned CODE_W = 4,
    parameter int unsigned SCALE  = 16,
    parameter int unsigned OFFSET = 6,
    parameter int unsigned CNT_W  = 9
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  limit
);

    localparam bit          SCALE_IS_POW2 = (SCALE != 0) && ((SCALE & (SCALE - 1)) == 0);
    localparam int unsigned SCALE_SHIFT   = (SCALE > 1) ? $clog2(SCALE) : 0;

    logic [CNT_W-1:0] biased;

    // Widen the code and add the fixed offset.
    always_comb begin
        biased = CNT_W'(code) + CNT_W'(OFFSET);
    end

    generate
        if (SCALE_IS_POW2) begin : g_shift
            // Scale by shifting when the factor is a power of two.
            always_comb begin
                limit = biased << SCALE_SHIFT;
            end
        end else begin : g_mult
            // Scale by a general multiply otherwise.
            always_comb begin
                limit = biased * CNT_W'(SCALE);
            end
        end
    endgenerate

endmodule

// File: rtl/dcf_candidate_tracker.sv
// Module: dcf_candidate_tracker
// Holds the candidate code and flags a restart whenever a ticked sample
// differs from it. Loads the raw code directly while the controller boots.
// Assumes: raw_code is already synchronous to clk.
module dcf_candidate_tracker #(
    parameter int unsigned CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              tick,
    input  logic [CODE_W-1:0] raw_code,
    output logic [CODE_W-1:0] cand,
    output logic              restart
);

    logic [CODE_W-1:0] cand_q;

    // A ticked sample that disagrees with the candidate starts a new candidate.
    always_comb begin
        restart = tick && !load && (raw_code != cand_q);
    end

    // Candidate register: loaded at boot, replaced on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q <= '0;
        end else if (load || restart) begin
            cand_q <= raw_code;
        end
    end

    assign cand = cand_q;

    // R6: an untimed edge outside boot leaves the candidate untouched.
    assert_cand_hold_untimed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tick) && !$past(load)) |-> $stable(cand_q));

endmodule

// File: rtl/dcf_settle_counter.sv
// Module: dcf_settle_counter
// Counts ticked edges on which the candidate held. Raises done on the edge
// that completes the limit, then returns to zero.
// Assumes: limit is at least 1 and changes only together with clear.
module dcf_settle_counter #(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    // Next count value and completion detect.
    always_comb begin
        cnt_inc = cnt_q + 1'b1;
        done    = advance && !clear && (cnt_inc == limit);
    end

    // Counter register: cleared on restart, idle or completion.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || done) begin
            cnt_q <= '0;
        end else if (advance) begin
            cnt_q <= cnt_inc;
        end
    end

    // R3: the count never reaches the limit of the candidate being timed.
    assert_count_below_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < limit);

endmodule

// File: rtl/dcf_publish_ctrl.sv
// Module: dcf_publish_ctrl
// Phase machine and output registers. It loads the effective code at boot,
// publishes a qualified candidate with a one-cycle strobe, and cancels when
// the raw code comes back to the published value.
// Assumes: restart and done come from the tracker and counter of the same top.
module dcf_publish_ctrl #(
    parameter int unsigned CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] raw_code,
    input  logic [CODE_W-1:0] cand,
    input  logic              restart,
    input  logic              done,
    output logic              load,
    output logic              timing,
    output logic [CODE_W-1:0] eff_code,
    output logic              upd_strobe
);
    import dcf_pkg::*;

    dcf_phase_e        phase_q, phase_d;
    logic [CODE_W-1:0] eff_q;
    logic              strobe_q;

    // Next-phase decision.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            DCF_BOOT: phase_d = DCF_IDLE;
            DCF_IDLE: if (restart) phase_d = DCF_QUAL;
            DCF_QUAL: begin
                if (restart && (raw_code == eff_q)) phase_d = DCF_IDLE;
                else if (done)                      phase_d = DCF_IDLE;
            end
            default:  phase_d = DCF_BOOT;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= DCF_BOOT;
        else        phase_q <= phase_d;
    end

    // Effective code: raw value at boot, candidate on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                  eff_q <= '0;
        else if (phase_q == DCF_BOOT) eff_q <= raw_code;
        else if (done)               eff_q <= cand;
    end

    // Update strobe: one cycle after each publication.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= done && (phase_q == DCF_QUAL);
    end

    assign load       = (phase_q == DCF_BOOT);
    assign timing     = (phase_q == DCF_QUAL);
    assign eff_code   = eff_q;
    assign upd_strobe = strobe_q;

    // R2: the value loaded when reset ends is the raw sample, with no strobe.
    assert_boot_load_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(phase_q) == DCF_BOOT) |-> (eff_q == $past(raw_code) && !strobe_q));

    // R7: a strobe always marks a real change of the effective code.
    assert_strobe_means_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |-> (eff_q != $past(eff_q)));

    // R7: outside the boot load, no change without the strobe.
    assert_change_needs_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(phase_q) != DCF_BOOT && !$stable(eff_q)) |-> strobe_q);

    // R7: the strobe never lasts two cycles.
    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |=> !strobe_q);

    // R8: the published value is the one the raw input held on the last edge.
    assert_no_intermediate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |-> (eff_q == $past(raw_code)));

    // R9: while idle, the candidate matches the published code.
    assert_idle_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == DCF_IDLE) |-> (cand == eff_q));

    // R5: a return to the published value cancels with no update.
    assert_cancel_no_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(phase_q) == DCF_QUAL && $past(restart)
         && $past(raw_code) == $past(eff_q)) |-> (!strobe_q && phase_q == DCF_IDLE));

endmodule

// File: rtl/divcode_settle_filter.sv
// Module: divcode_settle_filter (top)
// Filters a continuously sampled divider code. A differing value must hold
// for SCALE * (value + OFFSET) ticks before it becomes the effective code.
// Assumes: tick is a one-cycle enable synchronous to clk; raw_code is synchronous.
module divcode_settle_filter #(
    parameter int unsigned CODE_W = 4,
    parameter int unsigned SCALE  = 16,
    parameter int unsigned OFFSET = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CODE_W-1:0] raw_code,
    output logic [CODE_W-1:0] eff_code,
    output logic              upd_strobe
);
    import dcf_pkg::*;

    localparam int unsigned CNT_W = dcf_count_width(CODE_W, SCALE, OFFSET);

    logic [CODE_W-1:0] cand;
    logic              restart;
    logic              load;
    logic              timing;
    logic              done;
    logic              cnt_clear;
    logic              cnt_advance;
    logic [CNT_W-1:0]  limit;

    // Counter control: time only ticked, unchanged samples while qualifying.
    always_comb begin
        cnt_clear   = restart || !timing;
        cnt_advance = tick && timing;
    end

    dcf_candidate_tracker #(.CODE_W(CODE_W)) u_tracker (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .tick     (tick),
        .raw_code (raw_code),
        .cand     (cand),
        .restart  (restart)
    );

    dcf_limit_calc #(
        .CODE_W (CODE_W),
        .SCALE  (SCALE),
        .OFFSET (OFFSET),
        .CNT_W  (CNT_W)
    ) u_limit (
        .code  (cand),
        .limit (limit)
    );

    dcf_settle_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cnt_clear),
        .advance (cnt_advance),
        .limit   (limit),
        .done    (done)
    );

    dcf_publish_ctrl #(.CODE_W(CODE_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_code   (raw_code),
        .cand       (cand),
        .restart    (restart),
        .done       (done),
        .load       (load),
        .timing     (timing),
        .eff_code   (eff_code),
        .upd_strobe (upd_strobe)
    );

    // R6: a publication only follows a ticked edge.
    assert_strobe_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe |-> $past(tick));

endmodule

// File: tb/divcode_settle_filter_test.sv
module divcode_settle_filter_test;

    logic       clk      = 1'b0;
    logic       rst_n    = 1'b0;
    logic       tick     = 1'b0;
    logic [3:0] raw_code = 4'd0;
    logic [3:0] eff_code;
    logic       upd_strobe;

    int n_run  = 0;
    int n_fail = 0;
    int cur    = 0;

    always #5 clk = ~clk;

    divcode_settle_filter uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .raw_code   (raw_code),
        .eff_code   (eff_code),
        .upd_strobe (upd_strobe)
    );

    // Candidate sequence walked by the main loop, starting from code 5.
    localparam logic [3:0] SEQ [6] = '{4'd2, 4'd0, 4'd15, 4'd7, 4'd1, 4'd9};

    function automatic int settle_len(input int c);
        return 16 * (c + 6);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One clock edge with the given tick; sample 1 ns after the edge.
    task automatic step(input logic t);
        tick = t;
        @(posedge clk);
        #1;
    endtask

    // Run n ticked edges and count cycles where the output moved or strobed.
    task automatic quiet_ticks(input int n, output int moved);
        moved = 0;
        for (int i = 0; i < n; i++) begin
            step(1'b1);
            if (eff_code != 4'(cur) || upd_strobe) moved++;
        end
    endtask

    // Full qualification of a new code with edge-exact checks (R3, R7, R8).
    task automatic qualify(input int nv, input string req);
        int moved;
        raw_code = 4'(nv);
        quiet_ticks(settle_len(nv), moved);
        check(req, "early movement before L+1 ticks", moved, 0);
        check(req, "code held after L ticks", int'(eff_code), cur);
        step(1'b1);
        check(req, "code published after L+1 ticks", int'(eff_code), nv);
        check("R7", "strobe on publish", int'(upd_strobe), 1);
        step(1'b1);
        check("R7", "strobe one cycle only", int'(upd_strobe), 0);
        cur = nv;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        int moved;
        // R1: reset state.
        raw_code = 4'd5;
        rst_n    = 1'b0;
        step(1'b1);
        step(1'b1);
        check("R1", "eff_code in reset", int'(eff_code), 0);
        check("R1", "strobe in reset", int'(upd_strobe), 0);

        // R2: first edge after reset loads raw directly even without tick.
        rst_n = 1'b1;
        step(1'b0);
        check("R2", "boot load value", int'(eff_code), 5);
        check("R2", "no strobe at boot load", int'(upd_strobe), 0);
        cur = 5;

        // Table walk: R3 settle length for several codes, R8 direct jump.
        for (int k = 0; k < 6; k++) begin
            qualify(int'(SEQ[k]), "R3");
        end

        // R9: raw equal to effective code for a long time.
        raw_code = 4'(cur);
        quiet_ticks(400, moved);
        check("R9", "no activity when raw equals eff", moved, 0);

        // R5: excursion then return cancels; retry needs full time.
        raw_code = 4'd4;
        quiet_ticks(100, moved);
        raw_code = 4'(cur);
        quiet_ticks(200, moved);
        check("R5", "cancelled excursion no update", moved, 0);
        check("R5", "eff after cancel", int'(eff_code), 9);
        qualify(4, "R5");

        // R4: switch candidate mid-way; the first is never published.
        raw_code = 4'd12;
        quiet_ticks(150, moved);
        check("R4", "no publish of abandoned candidate", moved, 0);
        qualify(3, "R4");

        // R6: tick gaps neither advance nor restart.
        raw_code = 4'd10;
        quiet_ticks(100, moved);
        moved = 0;
        for (int i = 0; i < 300; i++) begin
            raw_code = (i < 100) ? 4'd1 : ((i < 200) ? 4'd3 : 4'd10);
            step(1'b0);
            if (eff_code != 4'(cur) || upd_strobe) moved++;
        end
        check("R6", "no movement with tick low", moved, 0);
        raw_code = 4'd10;
        quiet_ticks(settle_len(10) + 1 - 100 - 1, moved);
        check("R6", "progress kept across gap", moved, 0);
        step(1'b1);
        check("R6", "publish on remaining tick", int'(eff_code), 10);
        check("R7", "strobe after gap publish", int'(upd_strobe), 1);
        cur = 10;
        step(1'b1);

        // R6: alternating tick, only ticked edges count.
        raw_code = 4'd6;
        moved = 0;
        for (int i = 0; i < settle_len(6); i++) begin
            step(1'b1);
            if (eff_code != 4'(cur) || upd_strobe) moved++;
            step(1'b0);
            if (eff_code != 4'(cur) || upd_strobe) moved++;
        end
        check("R6", "alternating tick no early publish", moved, 0);
        step(1'b1);
        check("R6", "alternating tick publish", int'(eff_code), 6);
        step(1'b0);
        check("R7", "strobe clears on untimed edge", int'(upd_strobe), 0);
        cur = 6;

        // R1/R2: reset during qualification, then direct reload.
        raw_code = 4'd13;
        quiet_ticks(50, moved);
        rst_n = 1'b0;
        step(1'b1);
        check("R1", "eff cleared by reset", int'(eff_code), 0);
        rst_n = 1'b1;
        step(1'b0);
        check("R2", "reload after reset", int'(eff_code), 13);
        check("R2", "no strobe on reload", int'(upd_strobe), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule